// File: doc/BRIEF.md
# DLL Delay-Code Controller

This block is the digital loop filter of a delay-locked loop. A phase detector compares a reference clock with a feedback clock and reports, once per evaluation, whether the feedback edge was early or late. The feedback clock may be the loop's own primary output or an external or user clock. The controller turns each decision into a one-step move of a 6-bit tap-select code for the master delay chain. It keeps nudging the code until the two clocks line up and the decisions start to alternate.

The code also reaches two slave delay lines through a separately latched control bus. An update strobe refreshes that bus. A hold input freezes the code. A lock flag reports when the loop dithers around alignment. The code leaves the block in Gray form together with an increment pulse. A Gray-coded value can be imported to preset the code, and an increment-in pulse marks when that import takes place.

Decisions arrive on a valid/ready stream. A decision transfers on a clock edge where both `pd_valid` and `pd_ready` are high. `pd_ready` falls while hold is asserted, so the detector must keep its decision until hold is released. A decision offered without valid has no effect.

Top module: `dlc_ctrl_top`

## Requirements
- R1: After reset the code is 32 (mid-scale), `gray_o` is 6'b110000, `lock_o` is 0, `slave_code_o` is 0 and `inc_o` is 0.
- R2: A transferred decision moves the code by exactly one step on that clock edge. `pd_late`=0 (feedback early) moves it up; `pd_late`=1 moves it down.
- R3: The code saturates at 63 when stepping up and at 0 when stepping down. It never wraps.
- R4: While `hold_i` is 1 the code does not change, whatever is on the decision stream or the import lines.
- R5: On an edge with `upd_i`=1, `slave_code_o` takes the code value present before that edge. It keeps that value on every edge without `upd_i`, including while the code steps.
- R6: `gray_o` always equals code ^ (code >> 1).
- R7: On an edge with `inc_i`=1 and `hold_i`=0, the code loads the binary value of `gray_i` (bit i = XOR of `gray_i` bits 5 down to i). This takes priority over a decision on the same edge, which is consumed and discarded.
- R8: `inc_o` is 1 for exactly the cycle after an edge on which a decision raised the code by one. A saturated step, a down step or a load leaves it 0.
- R9: `lock_o` rises on the edge that completes LOCK_N consecutive direction changes between successive decisions (LOCK_N+1 alternating decisions; default LOCK_N=4).
- R10: `lock_o` falls on the edge of the (LOCK_N+1)-th consecutive same-direction decision. Saturated steps count toward the run. A load also clears lock and the direction history.
- R11: `pd_ready` equals the inverse of `hold_i`. An edge with `pd_valid`=0 leaves code, lock and `inc_o` unchanged or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (one evaluation per transfer) |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_valid | input | 1 | Phase decision present |
| pd_late | input | 1 | 1: feedback late (step down); 0: feedback early (step up) |
| pd_ready | output | 1 | Controller accepts a decision this cycle |
| hold_i | input | 1 | Freeze the code |
| upd_i | input | 1 | Copy current code onto the slave control bus |
| inc_i | input | 1 | Import strobe for `gray_i` |
| gray_i | input | 6 | Gray-coded code to import |
| code_o | output | 6 | Binary tap-select code for the master chain |
| slave_code_o | output | 6 | Latched code for the two slave delay lines |
| gray_o | output | 6 | Gray-coded copy of the code |
| inc_o | output | 1 | Pulse: code was incremented on the last edge |
| lock_o | output | 1 | Loop is dithering around alignment |

## Verification
Two pairs of functions can fall on the same edge. An update strobe can coincide with a step, and the slave bus must then show the pre-step code while `code_o` already shows the stepped one. An import strobe can coincide with a valid decision; the load must win, and `inc_o` and the lock history must behave as after a load. The bench drives both collisions deliberately, together with update during hold. The scoreboard, which models the code and the slave latch separately, judges each post-edge value.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int unsigned CODE_W = 6;
  localparam int unsigned LOCK_N = 4;

  typedef enum logic {
    DIR_DN = 1'b0,
    DIR_UP = 1'b1
  } dir_e;
endpackage

// File: rtl/dlc_gray_xlat.sv
module dlc_gray_xlat #(
  parameter int unsigned W = dlc_pkg::CODE_W
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  // export: adjacent-bit xor
  assign gray_o[W-1] = bin_i[W-1];
  // import: each binary bit is the parity of all Gray bits at or above it
  assign bin_o[W-1]  = gray_i[W-1];

  for (genvar i = 0; i < W - 1; i++) begin : g_bit
    assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
    assign bin_o[i]  = ^gray_i[W-1:i];
  end
endmodule

// File: rtl/dlc_code_acc.sv
module dlc_code_acc #(
  parameter int unsigned W = dlc_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         step_en,
  input  dlc_pkg::dir_e dir,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] code_o,
  output logic         inc_o
);
  localparam logic [W-1:0] CODE_MAX = '1;
  localparam logic [W-1:0] CODE_MIN = '0;
  localparam logic [W-1:0] CODE_MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q;
  logic         inc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= CODE_MID;
      inc_q  <= 1'b0;
    end else begin
      inc_q <= 1'b0;
      if (!hold) begin
        if (load_en) begin
          code_q <= load_val;
        end else if (step_en) begin
          if (dir == dlc_pkg::DIR_UP) begin
            if (code_q != CODE_MAX) begin
              code_q <= code_q + 1'b1;
              inc_q  <= 1'b1;
            end
          end else if (code_q != CODE_MIN) begin
            code_q <= code_q - 1'b1;
          end
        end
      end
    end
  end

  assign code_o = code_q;
  assign inc_o  = inc_q;

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !hold && dir == dlc_pkg::DIR_UP && code_q != CODE_MAX)
      |=> (code_q == $past(code_q) + 1'b1 && inc_q));
  p_step_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !hold && dir == dlc_pkg::DIR_DN && code_q != CODE_MIN)
      |=> (code_q == $past(code_q) - 1'b1 && !inc_q));
  p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !hold && dir == dlc_pkg::DIR_UP && code_q == CODE_MAX)
      |=> (code_q == CODE_MAX && !inc_q));
  p_sat_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !hold && dir == dlc_pkg::DIR_DN && code_q == CODE_MIN)
      |=> (code_q == CODE_MIN));
  p_hold_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(code_q) && !inc_q));
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !hold) |=> (code_q == $past(load_val) && !inc_q));
endmodule

// File: rtl/dlc_lock_det.sv
module dlc_lock_det #(
  parameter int unsigned LOCK_N = dlc_pkg::LOCK_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  dlc_pkg::dir_e dir,
  input  logic          clr,
  output logic          lock_o
);
  localparam int unsigned CW = $clog2(LOCK_N + 2);
  localparam logic [CW-1:0] ALT_TOP = CW'(LOCK_N);
  localparam logic [CW-1:0] RUN_TOP = CW'(LOCK_N + 1);

  logic [CW-1:0] alt_q, alt_d;
  logic [CW-1:0] run_q, run_d;
  logic          seen_q;
  dlc_pkg::dir_e last_q;
  logic          lock_q, lock_d;

  always_comb begin
    alt_d  = alt_q;
    run_d  = run_q;
    lock_d = lock_q;
    if (step_en) begin
      if (seen_q && dir != last_q) begin
        alt_d = (alt_q == ALT_TOP) ? alt_q : alt_q + 1'b1;
        run_d = CW'(1);
      end else begin
        alt_d = '0;
        run_d = !seen_q ? CW'(1) : ((run_q == RUN_TOP) ? run_q : run_q + 1'b1);
      end
      if (alt_d == ALT_TOP) lock_d = 1'b1;
      if (run_d == RUN_TOP) lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      alt_q  <= '0;
      run_q  <= '0;
      seen_q <= 1'b0;
      last_q <= dlc_pkg::DIR_DN;
      lock_q <= 1'b0;
    end else begin
      alt_q  <= alt_d;
      run_q  <= run_d;
      lock_q <= lock_d;
      if (step_en) begin
        seen_q <= 1'b1;
        last_q <= dir;
      end
    end
  end

  assign lock_o = lock_q;

  p_lock_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(step_en) && !$past(clr) && $past(seen_q) && $past(dir) != $past(last_q)));
  p_lock_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> ($past(clr) || ($past(step_en) && $past(dir) == $past(last_q))));
endmodule

// File: rtl/dlc_slave_latch.sv
module dlc_slave_latch #(
  parameter int unsigned W = dlc_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] bus_o
);
  logic [W-1:0] bus_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   bus_q <= '0;
    else if (upd) bus_q <= code_i;
  end

  assign bus_o = bus_q;

  p_latch_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (bus_q == $past(code_i)));
  p_latch_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(bus_q));
endmodule

// File: rtl/dlc_ctrl_top.sv
module dlc_ctrl_top #(
  parameter int unsigned W      = dlc_pkg::CODE_W,
  parameter int unsigned LOCK_N = dlc_pkg::LOCK_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pd_valid,
  input  logic         pd_late,
  output logic         pd_ready,
  input  logic         hold_i,
  input  logic         upd_i,
  input  logic         inc_i,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] slave_code_o,
  output logic [W-1:0] gray_o,
  output logic         inc_o,
  output logic         lock_o
);
  logic          load_fire;
  logic          step_fire;
  dlc_pkg::dir_e step_dir;
  logic [W-1:0]  import_bin;
  logic [W-1:0]  code_w;

  // decisions back-pressure while frozen; a load swallows a same-cycle decision
  assign pd_ready  = !hold_i;
  assign load_fire = inc_i && !hold_i;
  assign step_fire = pd_valid && pd_ready && !load_fire;
  assign step_dir  = pd_late ? dlc_pkg::DIR_DN : dlc_pkg::DIR_UP;

  dlc_gray_xlat #(.W(W)) u_xlat (
    .bin_i (code_w),
    .gray_o(gray_o),
    .gray_i(gray_i),
    .bin_o (import_bin)
  );

  dlc_code_acc #(.W(W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold_i),
    .step_en (step_fire),
    .dir     (step_dir),
    .load_en (load_fire),
    .load_val(import_bin),
    .code_o  (code_w),
    .inc_o   (inc_o)
  );

  dlc_lock_det #(.LOCK_N(LOCK_N)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_en(step_fire),
    .dir    (step_dir),
    .clr    (load_fire),
    .lock_o (lock_o)
  );

  dlc_slave_latch #(.W(W)) u_slave (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd_i),
    .code_i(code_w),
    .bus_o (slave_code_o)
  );

  assign code_o = code_w;

  p_gray_adj_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> ($countones(gray_o ^ $past(gray_o)) <= 1));
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_valid && !load_fire) |=> ($stable(code_w) && $stable(lock_o) && !inc_o));
endmodule

// File: tb/dlc_ctrl_top_tb_top.sv
module dlc_ctrl_top_tb_top;
  localparam int LN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_valid = 0, pd_late = 0, hold_i = 0, upd_i = 0, inc_i = 0;
  logic [5:0] gray_i = '0;
  logic       pd_ready, inc_o, lock_o;
  logic [5:0] code_o, slave_code_o, gray_o;

  always #5 clk = ~clk;

  dlc_ctrl_top #(.W(6), .LOCK_N(LN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_valid(pd_valid), .pd_late(pd_late),
    .pd_ready(pd_ready), .hold_i(hold_i), .upd_i(upd_i), .inc_i(inc_i),
    .gray_i(gray_i), .code_o(code_o), .slave_code_o(slave_code_o),
    .gray_o(gray_o), .inc_o(inc_o), .lock_o(lock_o)
  );

  typedef struct {
    int    code;
    int    slave;
    int    lock;
    int    inc;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  // reference model state
  int m_code = 32, m_slave = 0, m_lock = 0, m_alt = 0, m_run = 0, m_seen = 0, m_last = 0;

  function automatic int to_gray(int b);
    return (b ^ (b >> 1)) & 63;
  endfunction

  function automatic int from_gray(int g);
    int b = 0;
    for (int i = 5; i >= 0; i--) b |= ((((b >> (i + 1)) & 1) ^ ((g >> i) & 1)) << i);
    return b;
  endfunction

  task automatic note(bit ok, string tag, int act, int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // driver: apply one cycle of stimulus, advance the model, push expectation
  task automatic drive(bit v, bit late, bit h, bit u, bit inc, int gval, string tag);
    exp_t e;
    int   dir;
    @(negedge clk);
    pd_valid = v; pd_late = late; hold_i = h; upd_i = u; inc_i = inc; gray_i = 6'(gval);
    #1;
    note(pd_ready == !h, {"R11 ready ", tag}, pd_ready, !h);
    e.inc = 0;
    if (u) m_slave = m_code;
    if (!h) begin
      if (inc) begin
        m_code = from_gray(gval);
        m_lock = 0; m_alt = 0; m_run = 0; m_seen = 0;
      end else if (v) begin
        dir = late ? 0 : 1;
        if (dir == 1 && m_code < 63) begin m_code++; e.inc = 1; end
        if (dir == 0 && m_code > 0) m_code--;
        if (m_seen && dir != m_last) begin
          m_alt = (m_alt < LN) ? m_alt + 1 : LN;
          m_run = 1;
        end else begin
          m_alt = 0;
          m_run = !m_seen ? 1 : ((m_run < LN + 1) ? m_run + 1 : LN + 1);
        end
        m_seen = 1; m_last = dir;
        if (m_alt == LN) m_lock = 1;
        if (m_run == LN + 1) m_lock = 0;
      end
    end
    e.code = m_code; e.slave = m_slave; e.lock = m_lock; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        note(code_o == 6'(e.code), {e.tag, " code"}, code_o, e.code);
        note(gray_o == 6'(to_gray(e.code)), {"R6 gray ", e.tag}, gray_o, to_gray(e.code));
        note(slave_code_o == 6'(e.slave), {e.tag, " slave"}, slave_code_o, e.slave);
        note(lock_o == e.lock[0], {e.tag, " lock"}, lock_o, e.lock);
        note(inc_o == e.inc[0], {"R8 inc_o ", e.tag}, inc_o, e.inc);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    note(code_o == 6'd32, "R1 reset code", code_o, 32);
    note(gray_o == 6'b110000, "R1 reset gray", gray_o, 48);
    note(lock_o == 1'b0, "R1 reset lock", lock_o, 0);
    note(slave_code_o == 6'd0, "R1 reset slave", slave_code_o, 0);
    note(inc_o == 1'b0, "R1 reset inc_o", inc_o, 0);

    // R2 basic up and down steps
    drive(1, 0, 0, 0, 0, 0, "R2 up");
    drive(1, 0, 0, 0, 0, 0, "R2 up");
    drive(1, 1, 0, 0, 0, 0, "R2 down");
    // R11 idle cycles
    drive(0, 0, 0, 0, 0, 0, "R11 idle");
    drive(0, 1, 0, 0, 0, 0, "R11 idle");
    // R5 update colliding with a step: slave gets pre-step code
    drive(1, 0, 0, 1, 0, 0, "R5 upd+step");
    drive(1, 0, 0, 0, 0, 0, "R5 keep");
    drive(1, 1, 0, 0, 0, 0, "R5 keep");
    // R4 hold: decisions and import ignored, update still works
    drive(1, 0, 1, 0, 0, 0, "R4 hold");
    drive(1, 1, 1, 1, 1, 5, "R4 hold+upd+inc");
    drive(0, 0, 1, 0, 0, 0, "R4 hold");
    // R3 climb to top and saturate
    for (int i = 0; i < 36; i++) drive(1, 0, 0, 0, 0, 0, "R3 climb");
    drive(1, 0, 0, 1, 0, 0, "R3 sat hi");
    // R10 the long run above dropped any lock; now descend to 0
    for (int i = 0; i < 66; i++) drive(1, 1, 0, 0, 0, 0, "R3 descend");
    drive(1, 1, 0, 0, 0, 0, "R3 sat lo");
    // R7 import collides with a decision: load wins
    drive(1, 0, 0, 0, 1, to_gray(40), "R7 load+step");
    drive(0, 0, 0, 0, 1, to_gray(63), "R7 load 63");
    drive(0, 0, 0, 0, 1, to_gray(21), "R7 load 21");
    // R9 alternate to lock
    for (int i = 0; i < LN + 1; i++) drive(1, i[0], 0, 0, 0, 0, "R9 dither");
    drive(1, 0, 0, 0, 0, 0, "R9 dither hold lock");
    // R10 run of same direction drops lock on LN+1-th
    for (int i = 0; i < LN + 1; i++) drive(1, 1, 0, 0, 0, 0, "R10 run");
    // R9 relock then R10 clear by load
    for (int i = 0; i < LN + 1; i++) drive(1, ~i[0], 0, 0, 0, 0, "R9 relock");
    drive(0, 0, 0, 1, 1, to_gray(10), "R10 load clears lock");
    drive(1, 0, 0, 0, 0, 0, "R2 after load");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule